// File: doc/BRIEF.md
# Serial EEPROM Port with Power-Up Detect

This block owns the three output pins and the one input pin of a three-wire serial EEPROM (chip select, serial clock, serial data in to the memory, serial data out from the memory). Right after reset an internal sequencer takes the pins and streams the whole memory out in one sequential read. Each finished word is presented on a word output together with its index, so a neighbouring block can store it. Once the sequencer is finished, the pins go to the host. The host then moves them one bit at a time by writing a small control register, and it samples the memory's data line by reading the same register.

Whether a memory is fitted is decided during reset. The clock pin is not driven while reset is held, so an external pull resistor sets its level. The pin is sampled as an input on every clock edge in reset, and the value from the last such edge is kept as the presence flag. With no memory fitted, the sequencer never starts and reports completion at once.

The serial clock is made by dividing the system clock. Its high phase and its low phase each last `DIV` system clocks, and `DIV` is clamped to at least 4.

Top module: `eeprom_port`

## Requirements
- R1: Bit 0 of `host_rdata` always equals the current level of `do_pin_i`.
- R2: When the sequencer is not busy, a cycle with `host_we` high stores `host_wdata` into the host bits. From the next cycle on, `sk_pin_o` equals bit 1, `cs_pin_o` equals bit 2 and `di_pin_o` equals bit 3, and those values read back on the same positions of `host_rdata`.
- R3: A host write made while the sequencer is busy (`host_rdata` bit 5) is discarded. It changes neither the pins during the read nor the host bits read back after it.
- R4: On each rising clock edge with `rst` high, `sk_pin_i` is sampled. The value from the last such edge appears on `host_rdata` bit 4 as the presence flag, whatever was sampled on earlier edges.
- R5: While `rst` is held, from the first clock edge on, `pins_oe_o` is 0 and `sk_pin_o`, `cs_pin_o` and `di_pin_o` are 0.
- R6: With the presence flag at 0, the done flag (`host_rdata` bit 6) is 1 from the first clock edge after reset is released. The busy flag stays 0 and the sequencer never raises chip select.
- R7: With the presence flag at 1, the sequencer starts on the first clock edge after reset and holds chip select high for the whole read. In the first nine serial-clock periods it presents the command bits 1, 1, 0 and then six zero address bits on `di_pin_o`.
- R8: After the command, the sequencer samples `do_pin_i` on each rising serial-clock edge and assembles `NWORDS` words of `WORD_W` bits, first bit into the MSB. Each completed word is shown for one cycle on `word_valid`, `word_data` and `word_addr`, with indices 0, 1, 2 and so on in order.
- R9: During the read, every high phase and every low phase of the serial clock that lies between two rising edges lasts exactly `DIV` system clocks, with `DIV` raised to at least 4.
- R10: After the last data bit, the sequencer sets done and clears busy. It releases chip select, and the pins follow the host bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sk_pin_i | input | 1 | Level seen on the serial clock pin |
| do_pin_i | input | 1 | Serial data out from the memory |
| sk_pin_o | output | 1 | Serial clock driven to the pin |
| cs_pin_o | output | 1 | Chip select driven to the pin |
| di_pin_o | output | 1 | Serial data in driven to the memory |
| pins_oe_o | output | 1 | Output enable for the three driven pins |
| host_we | input | 1 | Control register write strobe |
| host_wdata | input | 3 | Write data for control bits 3..1 (di, cs, sk) |
| host_rdata | output | 7 | Control register read: done, busy, present, di, cs, sk, data-out |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_data | output | WORD_W | Completed word |
| word_addr | output | $clog2(NWORDS) | Index of the completed word |

## Verification
The bench builds the block with `DIV` at its minimum of 4 and with the default 64 words of 16 bits. This makes every slot the shortest legal one, so two complete reads of all 1033 slots fit easily, including the very last word address and the handover from sequencer to host. The first and last words are all ones and all zeros, and the words between are seeded pseudo-random. Resets with a pull level that changes on the final reset cycle show that only the last sample counts. Host writes scattered through a read show that writes during the read are discarded.

// File: rtl/eep_port_pkg.sv
package eep_port_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_RUN,
    SEQ_DONE
  } seq_state_e;

  // Serial clock half period in system clocks, never below four.
  function automatic uint_t half_period(input uint_t div);
    return (div < 4) ? 4 : div;
  endfunction

  // Read command: start bit 1, opcode 1 0, then an all-zero start address.
  function automatic logic read_cmd_bit(input uint_t idx);
    return idx < 2;
  endfunction

  // Word index for a data bit counted from the first data slot.
  function automatic uint_t word_of(input uint_t dbit, input uint_t wbits);
    return dbit / wbits;
  endfunction

  // True when a data bit is the last (LSB) bit of its word.
  function automatic logic last_bit_of_word(input uint_t dbit, input uint_t wbits);
    return (dbit % wbits) == wbits - 1;
  endfunction

endpackage

// File: rtl/eep_presence_latch.sv
module eep_presence_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic present_o
);
  logic present_q;

  // Sampled on every edge in reset; the final edge's value remains.
  always_ff @(posedge clk) begin
    if (rst) present_q <= pin_i;
  end

  assign present_o = present_q;
endmodule

// File: rtl/eep_sk_timer.sv
module eep_sk_timer #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sk_o,
  output logic rise_o,
  output logic slot_end_o
);
  localparam int unsigned PERIOD = 2 * HALF;
  localparam int PC_W = $clog2(PERIOD);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst || !run)                    pc_q <= '0;
    else if (pc_q == PC_W'(PERIOD - 1)) pc_q <= '0;
    else                                pc_q <= pc_q + 1'b1;
  end

  assign sk_o       = run && (pc_q >= PC_W'(HALF));
  assign rise_o     = run && (pc_q == PC_W'(HALF - 1));
  assign slot_end_o = run && (pc_q == PC_W'(PERIOD - 1));
endmodule

// File: rtl/eep_read_seq.sv
module eep_read_seq
  import eep_port_pkg::*;
#(
  parameter int unsigned HALF   = 4,
  parameter int unsigned NWORDS = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              present_i,
  input  logic              do_i,
  output logic              sk_o,
  output logic              cs_o,
  output logic              di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_data_o,
  output logic [ADDR_W-1:0] word_addr_o
);
  localparam int unsigned CMD_LEN = 3 + ADDR_W;
  localparam int unsigned TOTAL   = CMD_LEN + NWORDS * WORD_W;
  localparam int SLOT_W = $clog2(TOTAL);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [WORD_W-2:0] shift_q;
  logic              wvalid_q;
  logic [WORD_W-1:0] wdata_q;
  logic [ADDR_W-1:0] waddr_q;

  logic  run, rise, slot_end, in_data;
  uint_t slot_u, dbit;

  assign run     = (state_q == SEQ_RUN);
  assign slot_u  = uint_t'(slot_q);
  assign in_data = slot_u >= CMD_LEN;
  assign dbit    = slot_u - CMD_LEN;

  eep_sk_timer #(.HALF(HALF)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .sk_o      (sk_o),
    .rise_o    (rise),
    .slot_end_o(slot_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      slot_q   <= '0;
      shift_q  <= '0;
      wvalid_q <= 1'b0;
      wdata_q  <= '0;
      waddr_q  <= '0;
    end else begin
      wvalid_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: state_q <= present_i ? SEQ_RUN : SEQ_DONE;
        SEQ_RUN: begin
          if (rise && in_data) begin
            shift_q <= {shift_q[WORD_W-3:0], do_i};
            if (last_bit_of_word(dbit, WORD_W)) begin
              wvalid_q <= 1'b1;
              wdata_q  <= {shift_q, do_i};
              waddr_q  <= ADDR_W'(word_of(dbit, WORD_W));
            end
          end
          if (slot_end) begin
            if (slot_q == SLOT_W'(TOTAL - 1)) state_q <= SEQ_DONE;
            else                              slot_q  <= slot_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign cs_o         = run;
  assign di_o         = run && !in_data && read_cmd_bit(slot_u);
  assign busy_o       = run;
  assign done_o       = (state_q == SEQ_DONE);
  assign word_valid_o = wvalid_q;
  assign word_data_o  = wdata_q;
  assign word_addr_o  = waddr_q;
endmodule

// File: rtl/eep_pin_owner.sv
module eep_pin_owner (
  input  logic       clk,
  input  logic       rst,
  input  logic       seq_busy_i,
  input  logic       seq_sk_i,
  input  logic       seq_cs_i,
  input  logic       seq_di_i,
  input  logic       host_we_i,
  input  logic [2:0] host_wdata_i,
  output logic [2:0] host_q_o,
  output logic       sk_o,
  output logic       cs_o,
  output logic       di_o,
  output logic       oe_o
);
  // host_q bit order: [0] clock, [1] chip select, [2] data in
  logic [2:0] host_q;
  logic       oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      host_q <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= 1'b1;
      if (host_we_i && !seq_busy_i) host_q <= host_wdata_i;
    end
  end

  assign sk_o     = oe_q & (seq_busy_i ? seq_sk_i : host_q[0]);
  assign cs_o     = oe_q & (seq_busy_i ? seq_cs_i : host_q[1]);
  assign di_o     = oe_q & (seq_busy_i ? seq_di_i : host_q[2]);
  assign oe_o     = oe_q;
  assign host_q_o = host_q;
endmodule

// File: rtl/eeprom_port.sv
module eeprom_port
  import eep_port_pkg::*;
#(
  parameter int unsigned DIV    = 4,
  parameter int unsigned NWORDS = 64,
  parameter int unsigned WORD_W = 16,
  localparam int unsigned ADDR_W = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sk_pin_i,
  input  logic              do_pin_i,
  output logic              sk_pin_o,
  output logic              cs_pin_o,
  output logic              di_pin_o,
  output logic              pins_oe_o,
  input  logic              host_we,
  input  logic [3:1]        host_wdata,
  output logic [6:0]        host_rdata,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int unsigned HALF = half_period(DIV);

  logic       present_q;
  logic       seq_busy, seq_done, seq_sk, seq_cs, seq_di;
  logic [2:0] host_q;

  eep_presence_latch u_presence (
    .clk      (clk),
    .rst      (rst),
    .pin_i    (sk_pin_i),
    .present_o(present_q)
  );

  eep_read_seq #(.HALF(HALF), .NWORDS(NWORDS), .WORD_W(WORD_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .present_i   (present_q),
    .do_i        (do_pin_i),
    .sk_o        (seq_sk),
    .cs_o        (seq_cs),
    .di_o        (seq_di),
    .busy_o      (seq_busy),
    .done_o      (seq_done),
    .word_valid_o(word_valid),
    .word_data_o (word_data),
    .word_addr_o (word_addr)
  );

  eep_pin_owner u_owner (
    .clk         (clk),
    .rst         (rst),
    .seq_busy_i  (seq_busy),
    .seq_sk_i    (seq_sk),
    .seq_cs_i    (seq_cs),
    .seq_di_i    (seq_di),
    .host_we_i   (host_we),
    .host_wdata_i(host_wdata[3:1]),
    .host_q_o    (host_q),
    .sk_o        (sk_pin_o),
    .cs_o        (cs_pin_o),
    .di_o        (di_pin_o),
    .oe_o        (pins_oe_o)
  );

  // 6 done, 5 busy, 4 present, 3 data-in, 2 select, 1 clock, 0 data-out pin
  assign host_rdata = {seq_done, seq_busy, present_q, host_q[2], host_q[1], host_q[0], do_pin_i};
endmodule

// File: rtl/eep_port_checker.sv
module eep_port_checker #(
  parameter int unsigned HALF = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       sk_o,
  input logic       cs_o,
  input logic       oe,
  input logic       busy,
  input logic       done,
  input logic       present,
  input logic       host_we,
  input logic [2:0] host_q,
  input logic       word_valid
);
  logic        rst_q = 1'b0;
  int unsigned hi_len = 0;

  always @(posedge clk) begin
    rst_q <= rst;
    if (sk_o) begin
      if (hi_len < 1000) hi_len <= hi_len + 1;
    end else begin
      hi_len <= 0;
    end
  end

  // R5: pins released and low once reset has been seen on an edge
  always @(posedge clk) begin
    if (rst_q) assert_pins_idle_in_reset_R5: assert (!oe && !sk_o && !cs_o);
  end

  assert_host_write_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && host_we) |=> $stable(host_q));

  assert_no_read_when_absent_R6: assert property (@(posedge clk) disable iff (rst)
    !present |-> !busy);

  assert_select_held_R7: assert property (@(posedge clk) disable iff (rst)
    busy |-> cs_o);

  assert_word_only_in_read_R8: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> busy);

  assert_high_phase_len_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(sk_o) && $past(busy)) |-> (hi_len == HALF));

  assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

bind eeprom_port eep_port_checker #(.HALF(HALF)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sk_o      (sk_pin_o),
  .cs_o      (cs_pin_o),
  .oe        (pins_oe_o),
  .busy      (seq_busy),
  .done      (seq_done),
  .present   (present_q),
  .host_we   (host_we),
  .host_q    (host_q),
  .word_valid(word_valid)
);

// File: tb/sim_eeprom_port.sv
module sim_eeprom_port;
  localparam int DIV     = 4;
  localparam int NWORDS  = 64;
  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 6;
  localparam int CMD_LEN = 9;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst = 1'b1;
  logic              sk_pull = 1'b1, host_do = 1'b0, model_on = 1'b0, do_model = 1'b0;
  logic              host_we = 1'b0;
  logic [3:1]        host_wdata = '0;
  logic              sk_pin_i, do_pin_i, sk_o, cs_o, di_o, oe;
  logic [6:0]        rdata;
  logic              word_valid;
  logic [WORD_W-1:0] word_data;
  logic [ADDR_W-1:0] word_addr;

  assign sk_pin_i = oe ? sk_o : sk_pull;
  assign do_pin_i = model_on ? do_model : host_do;

  eeprom_port #(.DIV(DIV), .NWORDS(NWORDS), .WORD_W(WORD_W)) u0 (
    .clk(clk), .rst(rst), .sk_pin_i(sk_pin_i), .do_pin_i(do_pin_i),
    .sk_pin_o(sk_o), .cs_pin_o(cs_o), .di_pin_o(di_o), .pins_oe_o(oe),
    .host_we(host_we), .host_wdata(host_wdata), .host_rdata(rdata),
    .word_valid(word_valid), .word_data(word_data), .word_addr(word_addr)
  );

  int checks = 0, errors = 0, cyc = 0;
  int unsigned seed = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input int w);
    if (w == 0) return '1;
    if (w == NWORDS - 1) return '0;
    return WORD_W'(w * 40503 + seed) ^ WORD_W'(w << 9);
  endfunction

  function automatic logic exp_do(input int s);
    logic [WORD_W-1:0] v;
    int d;
    if (s < CMD_LEN) return 1'b0;
    d = s - CMD_LEN;
    v = pat(d / WORD_W);
    return v[WORD_W - 1 - (d % WORD_W)];
  endfunction

  // Memory model and serial-clock observer
  int   n_rise = 0, exp_idx = 0, run_len = 0;
  logic prev_sk = 1'b0;
  bit   seen_high = 0;

  always @(negedge clk) begin
    if (rst || !cs_o || !model_on) begin
      n_rise = 0;
    end else if (sk_o && !prev_sk) begin
      if (n_rise < CMD_LEN)
        check(di_o == (n_rise < 2), "R7 command bit", di_o, n_rise < 2);
      n_rise++;
    end
    do_model = exp_do(n_rise);

    if (rst) exp_idx = 0;
    else if (word_valid && model_on) begin
      check(word_addr == ADDR_W'(exp_idx), "R8 word index", word_addr, exp_idx);
      check(word_data == pat(exp_idx), "R8 word data", word_data, pat(exp_idx));
      exp_idx++;
    end

    if (rst || !rdata[5]) begin
      run_len = 0;
      seen_high = 0;
    end else if (sk_o != prev_sk) begin
      if (prev_sk) begin
        check(run_len == DIV, "R9 high phase", run_len, DIV);
        seen_high = 1;
      end else if (seen_high) begin
        check(run_len == DIV, "R9 low phase", run_len, DIV);
      end
      run_len = 1;
    end else begin
      run_len++;
    end
    prev_sk = sk_o;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset(input logic early, input logic last);
    rst = 1'b1;
    sk_pull = early;
    repeat (4) @(negedge clk);
    check(!oe && !sk_o && !cs_o && !di_o, "R5 pins idle in reset", {oe, sk_o, cs_o, di_o}, 0);
    sk_pull = last;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdata[4] == last, "R4 presence from last reset edge", rdata[4], last);
  endtask

  task automatic run_read(input string tag);
    int guard = 0;
    check(rdata[5] == 1'b1 && cs_o == 1'b1, "R7 read started", {rdata[5], cs_o}, 3);
    while (!rdata[6] && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (exp_idx < NWORDS - 2 && ($urandom % 97) == 0) begin
        host_we = 1'b1;
        host_wdata = 3'($urandom);
        @(negedge clk);
        host_we = 1'b0;
        check(cs_o == 1'b1, "R3 write during read leaves select", cs_o, 1);
      end
    end
    check(exp_idx == NWORDS, {"R8 word count ", tag}, exp_idx, NWORDS);
    check(rdata[6] && !rdata[5], "R10 done and not busy", rdata[6:5], 2);
    check(!cs_o && !sk_o && !di_o, "R10 pins follow host after read", {cs_o, sk_o, di_o}, 0);
    check(rdata[3:1] == 3'b000, "R3 host bits untouched by writes in read", rdata[3:1], 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    seed = $urandom;

    // Read with the pull high on every reset edge
    model_on = 1'b1;
    do_reset(1'b1, 1'b1);
    run_read("first");

    // Host bit-bang after the read
    model_on = 1'b0;
    for (int i = 0; i < 24; i++) begin
      logic [2:0] v;
      v = 3'($urandom);
      if (i == 0) v = 3'b111;
      if (i == 1) v = 3'b000;
      @(negedge clk);
      host_we = 1'b1;
      host_wdata = v;
      @(negedge clk);
      host_we = 1'b0;
      check(sk_o == v[0] && cs_o == v[1] && di_o == v[2], "R2 pins follow host bits",
            {di_o, cs_o, sk_o}, v);
      check(rdata[3:1] == v, "R2 host bits read back", rdata[3:1], v);
      host_do = 1'($urandom);
      #1;
      check(rdata[0] == host_do, "R1 data-out visible in bit 0", rdata[0], host_do);
    end

    // Pull high early in reset but low on the final edge: absent
    do_reset(1'b1, 1'b0);
    check(rdata[6] && !rdata[5], "R6 done at once when absent", rdata[6:5], 2);
    begin
      bit any_cs = 0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        any_cs |= cs_o | rdata[5];
      end
      check(!any_cs, "R6 no select while absent", any_cs, 0);
    end

    // Pull low early but high on the final edge: present, second read
    seed = $urandom;
    model_on = 1'b1;
    do_reset(1'b0, 1'b1);
    run_read("second");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule